// File: doc/BRIEF.md
# Write-back three-state snoop controller

This block is the coherence controller for one private write-back cache on a shared, atomic snooping bus. It holds a direct-mapped array of lines. Each line has a tag, one data word and a state: Invalid, Shared (clean, read-only) or Exclusive (the only copy, writable and dirty). The controller serves processor reads and writes. On a miss it allocates the line, so writes to clean or absent blocks also take the miss path. It puts read-miss, write-miss and write-back transactions on the bus. A conflicting dirty line is written back before its replacement is fetched.

The controller also watches the misses that other caches place on the bus. A write miss from elsewhere invalidates a clean copy held here. When this cache holds the block dirty, it supplies the block with a write-back and raises a memory-abort flag in the same bus cycle, so that memory withholds its own data. A snoop always wins over a processor request offered in the same cycle. A processor request that misses is held until its bus sequence completes.

Top module: `wb_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_cmd` is 0 (idle), and `cpu_ack` and `mem_abort` are low.
- R2: A processor read of an Invalid line drives `bus_cmd`=1 (read miss) with `bus_addr` equal to the request address in the cycle after acceptance. In the next cycle `cpu_ack` rises with `cpu_rdata` equal to the `bus_rdata` sampled during the miss cycle, and the line becomes Shared.
- R3: A processor write to an Invalid line, or to a Shared line with the same tag, drives `bus_cmd`=2 (write miss) and leaves the line Exclusive, holding the written data. `cpu_ack` rises one cycle after the miss.
- R4: A read hitting a Shared or Exclusive line, or a write hitting an Exclusive line, raises `cpu_ack` one cycle after acceptance with no bus command and no state change. A read hit returns the stored word.
- R5: A snooped write miss (`snp_cmd`=2) to a block held Shared leaves the bus idle and makes the line Invalid, so the next processor read of that block misses.
- R6: A snooped read miss (`snp_cmd`=1) to a block held Exclusive drives, in the next cycle, `bus_cmd`=3 (write-back) with the block's address and data and `mem_abort` high. The line becomes Shared: reads then hit, and a write takes the write-miss path.
- R7: A snooped write miss to a block held Exclusive produces the same write-back with `mem_abort` high, and the line becomes Invalid.
- R8: A processor read missing on an index whose line is Exclusive with another tag first drives a write-back of the old block (address = old tag and index, `mem_abort` low). It then drives a read miss for the new address, and the line ends Shared.
- R9: A processor write missing on an index whose line is Exclusive with another tag drives a write-back of the old block, then a write miss, and the line ends Exclusive with the new data.
- R10: A processor read missing on an index whose line is Shared with another tag drives only a read miss, with no write-back.
- R11: When `snp_valid` and `cpu_req` are both high with the controller idle, the snoop is served first. The processor request is served in the following cycle, and a read of a block just downgraded by that snoop hits.
- R12: A snoop that misses in the array, or a snooped read miss to a Shared line, leaves the bus idle and the line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor block address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_ack` |
| snp_valid | input | 1 | Another cache's miss is on the bus |
| snp_cmd | input | 2 | Snooped kind: 1 read miss, 2 write miss |
| snp_addr | input | ADDR_W | Snooped block address |
| bus_cmd | output | 2 | 0 idle, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the bus command |
| bus_wdata | output | DATA_W | Block data for a write-back |
| mem_abort | output | 1 | Memory must not answer; this cache supplies the block |
| bus_rdata | input | DATA_W | Fill data, sampled during a miss cycle |

## Verification
Every result is registered. A hit acknowledges one cycle after the request is accepted, and a snoop write-back with abort appears one cycle after the snoop. A clean miss shows its bus command one cycle after acceptance and its acknowledge one cycle later. A dirty conflict adds one write-back cycle in front of that. The bench inputs change on the falling edge. A behavioural model advances on each rising edge from the same inputs and predicts the outputs of the cycle just starting. Those predictions are compared on the following falling edge, so each result is read in exactly the cycle it is due, and an early or late pulse is reported as a mismatch.

// File: rtl/coh_pkg.sv
package coh_pkg;
    parameter int ADDR_W = 8;
    parameter int IDX_W  = 2;
    parameter int DATA_W = 8;

    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int LINES = 1 << IDX_W;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } lstate_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bcmd_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WB   = 2'd1,
        FS_MISS = 2'd2
    } fsm_e;

    typedef struct packed {
        lstate_e             st;
        logic [TAG_W-1:0]    tag;
        logic [DATA_W-1:0]   data;
    } line_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output line_t [NRD-1:0]            rd_line,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  line_t                      wr_line
);
    line_t lines_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) lines_q[i] <= '0;
        end else if (wr_en) begin
            lines_q[wr_idx] <= wr_line;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_line[p] = lines_q[rd_idx[p]];
    end

    // R1: the cycle after reset every read port reports an empty line
    a_r1_lines_invalid: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_line[0].st == LS_INV && rd_line[NRD-1].st == LS_INV));
endmodule

// File: rtl/coh_snoop_resolve.sv
module coh_snoop_resolve
    import coh_pkg::*;
(
    input  bcmd_e             req,
    input  logic [TAG_W-1:0]  req_tag,
    input  line_t             cur,
    output logic              upd,
    output logic              supply,
    output lstate_e           nst
);
    logic match;

    always_comb begin
        match  = (cur.st != LS_INV) && (cur.tag == req_tag);
        supply = match && (cur.st == LS_EXC);
        upd    = supply || (match && req == BC_WRMISS);
        nst    = (supply && req == BC_RDMISS) ? LS_SHR : LS_INV;
    end
endmodule

// File: rtl/wb_snoop_ctrl.sv
module wb_snoop_ctrl
    import coh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              mem_abort,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int P_CPU = 0;
    localparam int P_SNP = 1;

    logic [1:0][IDX_W-1:0] rd_idx;
    line_t [1:0]           rd_line;
    line_t                 cpu_line, snp_line, wr_line;
    logic                  wr_en;
    logic [IDX_W-1:0]      wr_idx;

    logic    s_upd, s_supply;
    lstate_e s_nst;
    logic    cpu_hit;

    fsm_e              fs_q, fs_d;
    logic              pwe_q, pwe_d;
    logic [ADDR_W-1:0] padr_q, padr_d;
    logic [DATA_W-1:0] pwd_q, pwd_d;
    bcmd_e             cmd_q, cmd_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] wdat_q, wdat_d;
    logic              abort_q, abort_d;
    logic              ack_q, ack_d;
    logic [DATA_W-1:0] rdat_q, rdat_d;
    logic [DATA_W-1:0] fill_data;

    assign rd_idx[P_CPU] = idx_of(cpu_addr);
    assign rd_idx[P_SNP] = idx_of(snp_addr);
    assign cpu_line      = rd_line[P_CPU];
    assign snp_line      = rd_line[P_SNP];
    assign cpu_hit       = (cpu_line.st != LS_INV) && (cpu_line.tag == tag_of(cpu_addr));
    assign fill_data     = pwe_q ? pwd_q : bus_rdata;

    coh_line_store #(.NRD(2)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_line (rd_line),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_line (wr_line)
    );

    coh_snoop_resolve u_snoop (
        .req     (bcmd_e'(snp_cmd)),
        .req_tag (tag_of(snp_addr)),
        .cur     (snp_line),
        .upd     (s_upd),
        .supply  (s_supply),
        .nst     (s_nst)
    );

    always_comb begin
        fs_d    = fs_q;
        pwe_d   = pwe_q;
        padr_d  = padr_q;
        pwd_d   = pwd_q;
        cmd_d   = BC_NONE;
        addr_d  = addr_q;
        wdat_d  = wdat_q;
        abort_d = 1'b0;
        ack_d   = 1'b0;
        rdat_d  = rdat_q;
        wr_en   = 1'b0;
        wr_idx  = idx_of(cpu_addr);
        wr_line = cpu_line;
        unique case (fs_q)
            FS_IDLE: begin
                if (snp_valid) begin
                    if (s_upd) begin
                        wr_en      = 1'b1;
                        wr_idx     = idx_of(snp_addr);
                        wr_line    = snp_line;
                        wr_line.st = s_nst;
                    end
                    if (s_supply) begin
                        cmd_d   = BC_WBACK;
                        addr_d  = snp_addr;
                        wdat_d  = snp_line.data;
                        abort_d = 1'b1;
                    end
                end else if (cpu_req) begin
                    if (cpu_hit && !cpu_we) begin
                        ack_d  = 1'b1;
                        rdat_d = cpu_line.data;
                    end else if (cpu_hit && cpu_we && cpu_line.st == LS_EXC) begin
                        ack_d        = 1'b1;
                        rdat_d       = cpu_wdata;
                        wr_en        = 1'b1;
                        wr_line.data = cpu_wdata;
                    end else begin
                        pwe_d  = cpu_we;
                        padr_d = cpu_addr;
                        pwd_d  = cpu_wdata;
                        if (cpu_line.st == LS_EXC) begin
                            cmd_d  = BC_WBACK;
                            addr_d = {cpu_line.tag, idx_of(cpu_addr)};
                            wdat_d = cpu_line.data;
                            fs_d   = FS_WB;
                        end else begin
                            cmd_d  = cpu_we ? BC_WRMISS : BC_RDMISS;
                            addr_d = cpu_addr;
                            fs_d   = FS_MISS;
                        end
                    end
                end
            end
            FS_WB: begin
                cmd_d  = pwe_q ? BC_WRMISS : BC_RDMISS;
                addr_d = padr_q;
                fs_d   = FS_MISS;
            end
            FS_MISS: begin
                wr_en   = 1'b1;
                wr_idx  = idx_of(padr_q);
                wr_line = '{st: (pwe_q ? LS_EXC : LS_SHR), tag: tag_of(padr_q), data: fill_data};
                ack_d   = 1'b1;
                rdat_d  = fill_data;
                fs_d    = FS_IDLE;
            end
            default: fs_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q    <= FS_IDLE;
            pwe_q   <= 1'b0;
            padr_q  <= '0;
            pwd_q   <= '0;
            cmd_q   <= BC_NONE;
            addr_q  <= '0;
            wdat_q  <= '0;
            abort_q <= 1'b0;
            ack_q   <= 1'b0;
            rdat_q  <= '0;
        end else begin
            fs_q    <= fs_d;
            pwe_q   <= pwe_d;
            padr_q  <= padr_d;
            pwd_q   <= pwd_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            wdat_q  <= wdat_d;
            abort_q <= abort_d;
            ack_q   <= ack_d;
            rdat_q  <= rdat_d;
        end
    end

    assign bus_cmd   = cmd_q;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdat_q;
    assign mem_abort = abort_q;
    assign cpu_ack   = ack_q;
    assign cpu_rdata = rdat_q;

    // R1: outputs are quiet right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_cmd == BC_NONE && !cpu_ack && !mem_abort));
    // R6 / R7: an abort only accompanies a write-back
    a_r6_abort_with_wback: assert property (@(posedge clk) disable iff (rst)
        mem_abort |-> bus_cmd == BC_WBACK);
    // R8 / R9: a replacement write-back is followed by the miss itself
    a_r8_wback_then_miss: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == BC_WBACK && !mem_abort) |=> (bus_cmd == BC_RDMISS || bus_cmd == BC_WRMISS));
    // R2 / R3: a miss is acknowledged in the next cycle
    a_r2_miss_then_ack: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == BC_RDMISS || bus_cmd == BC_WRMISS) |=> cpu_ack);
    // R4: completion is a single-cycle pulse
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);
    // R11: a snoop taken while idle never completes a processor request in that slot
    a_r11_snoop_first: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && fs_q == FS_IDLE) |=> !cpu_ack);
endmodule

// File: tb/tb_wb_snoop_ctrl.sv
module tb_wb_snoop_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_ack;
    logic [7:0] cpu_rdata;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr, bus_wdata;
    logic       mem_abort;
    logic [7:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    wb_snoop_ctrl dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mem_abort(mem_abort), .bus_rdata(bus_rdata)
    );

    int    n_tests = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";
    int    mem [256];

    // behavioural reference: 4 lines, index = addr % 4, tag = addr / 4
    int m_st [4];
    int m_tag [4];
    int m_data [4];
    int m_ph = 0;
    int p_we, p_addr, p_wd;
    int e_cmd = 0, e_addr = 0, e_wdata = 0, e_abort = 0, e_ack = 0, e_rdata = 0, e_rd = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_data[i] = 0; end
            m_ph = 0; e_cmd = 0; e_abort = 0; e_ack = 0;
        end else begin
            int i, t;
            e_cmd = 0; e_abort = 0; e_ack = 0;
            if (m_ph == 0) begin
                if (snp_valid) begin
                    i = snp_addr % 4; t = snp_addr / 4;
                    if (m_st[i] != 0 && m_tag[i] == t) begin
                        if (m_st[i] == 2) begin
                            e_cmd = 3; e_addr = snp_addr; e_wdata = m_data[i]; e_abort = 1;
                            m_st[i] = (snp_cmd == 1) ? 1 : 0;
                        end else if (snp_cmd == 2) begin
                            m_st[i] = 0;
                        end
                    end
                end else if (cpu_req) begin
                    i = cpu_addr % 4; t = cpu_addr / 4;
                    if (!cpu_we && m_st[i] != 0 && m_tag[i] == t) begin
                        e_ack = 1; e_rd = 1; e_rdata = m_data[i];
                    end else if (cpu_we && m_st[i] == 2 && m_tag[i] == t) begin
                        e_ack = 1; e_rd = 0; m_data[i] = cpu_wdata;
                    end else begin
                        p_we = cpu_we; p_addr = cpu_addr; p_wd = cpu_wdata;
                        if (m_st[i] == 2) begin
                            e_cmd = 3; e_addr = m_tag[i] * 4 + i; e_wdata = m_data[i]; m_ph = 1;
                        end else begin
                            e_cmd = p_we ? 2 : 1; e_addr = p_addr; m_ph = 2;
                        end
                    end
                end
            end else if (m_ph == 1) begin
                e_cmd = p_we ? 2 : 1; e_addr = p_addr; m_ph = 2;
            end else begin
                i = p_addr % 4;
                m_st[i] = p_we ? 2 : 1; m_tag[i] = p_addr / 4;
                m_data[i] = p_we ? p_wd : int'(bus_rdata);
                e_ack = 1; e_rd = !p_we; e_rdata = m_data[i]; m_ph = 0;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // compare every cycle, then play the memory side of the bus
    always @(negedge clk) begin
        if (!rst) begin
            chk("bus_cmd", int'(bus_cmd), e_cmd);
            chk("mem_abort", int'(mem_abort), e_abort);
            chk("cpu_ack", int'(cpu_ack), e_ack);
            if (e_cmd != 0) chk("bus_addr", int'(bus_addr), e_addr);
            if (e_cmd == 3) chk("bus_wdata", int'(bus_wdata), e_wdata);
            if (e_ack && e_rd) chk("cpu_rdata", int'(cpu_rdata), e_rdata);
            if (bus_cmd == 2'd3) mem[bus_addr] = int'(bus_wdata);
            bus_rdata = mem[bus_addr][7:0];
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_ack();
        do @(negedge clk); while (!cpu_ack);
        cpu_req = 1'b0;
    endtask

    task automatic cpu_op(input string req, input bit we, input int a, input int d);
        @(negedge clk);
        cur_req = req;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a[7:0]; cpu_wdata = d[7:0];
        wait_ack();
    endtask

    task automatic snoop(input string req, input int cmd, input int a);
        @(negedge clk);
        cur_req = req;
        snp_valid = 1'b1; snp_cmd = cmd[1:0]; snp_addr = a[7:0];
        @(negedge clk);
        snp_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = (a ^ 8'h5A) & 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);                 // R1 idle outputs
        cpu_op("R2", 0, 8'h10, 0);                 // read miss, Invalid
        cpu_op("R4", 0, 8'h10, 0);                 // read hit Shared
        cpu_op("R3", 1, 8'h10, 8'hA1);             // write to Shared: write miss
        cpu_op("R4", 1, 8'h10, 8'hA2);             // write hit Exclusive
        cpu_op("R4", 0, 8'h10, 0);                 // read hit Exclusive
        cpu_op("R3", 1, 8'h21, 8'hB1);             // write to Invalid
        snoop("R6", 1, 8'h10);                     // read-miss snoop on Exclusive
        cpu_op("R6", 0, 8'h10, 0);                 // now Shared: hit
        cpu_op("R6", 1, 8'h10, 8'hC3);             // Shared write: miss
        snoop("R7", 2, 8'h10);                     // write-miss snoop on Exclusive
        cpu_op("R7", 0, 8'h10, 0);                 // Invalid: read miss
        snoop("R5", 2, 8'h10);                     // write-miss snoop on Shared
        cpu_op("R5", 0, 8'h10, 0);                 // Invalid again: miss
        snoop("R12", 1, 8'h10);                    // read snoop on Shared: nothing
        snoop("R12", 2, 8'h30);                    // other tag: nothing
        cpu_op("R12", 0, 8'h10, 0);                // still Shared: hit
        cpu_op("R10", 0, 8'h20, 0);                // conflict with Shared
        cpu_op("R8", 1, 8'h22, 8'hD4);             // make index 2 Exclusive
        cpu_op("R8", 0, 8'h32, 0);                 // conflict with Exclusive: wb + read miss
        cpu_op("R8", 0, 8'h32, 0);                 // ends Shared: hit
        cpu_op("R9", 1, 8'h23, 8'hE5);
        cpu_op("R9", 1, 8'h33, 8'hE6);             // wb + write miss
        cpu_op("R9", 0, 8'h33, 0);                 // Exclusive: hit with new data
        cpu_op("R11", 1, 8'h11, 8'hF7);            // index 1 Exclusive (replaces 0x21)
        @(negedge clk);
        cur_req = "R11";
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h11;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h11;
        @(negedge clk);
        snp_valid = 1'b0;
        if (cpu_ack) wait_ack(); else wait_ack();
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule